// File: doc/BRIEF.md
# Set/Clear GPIO Flag Controller

This block manages a bank of general-purpose flag pins. Each pin is an input or an output, as chosen by its direction bit. Software raises output levels by writing ones to a set register and lowers them by writing ones to a clear register. Bits written as zero are left alone, so a single write can change any group of pins without a read-modify-write. A status read returns the level of every flag. For an output pin that level is the driven value. For an input pin it is the input after a two-flop synchronizer.

Each pin can raise an interrupt. The enables are changed through separate mask-set and mask-clear writes. A sensitivity register picks level or edge detection per pin, and a second register picks rising-only or both-edge detection for pins in edge mode. Input pins are watched at their synchronized input. Output pins are watched at their driven level, so a software write that changes an output can raise a software interrupt. Edge events are held in sticky latches until software writes one to the clear register for that bit. All masked pending sources are ORed into a single interrupt output.

Top module: `gpio_flag_ctrl`

## Requirements
- R1: After reset, direction, output, mask, edge-select and both-edge registers are all zero, so every pin is an input, pin_out and pin_oe are zero and irq is low.
- R2: A write to address 0 loads the direction register with wr_data (1 = output). pin_oe equals the direction register, which reads back at read address 0.
- R3: A write to address 1 sets every output-latch bit whose wr_data bit is one and leaves the other bits unchanged. pin_out shows the latch from the next cycle.
- R4: A write to address 2 clears every output-latch bit whose wr_data bit is one and leaves the other bits unchanged.
- R5: Read address 1 returns the pin status. An output pin reads as its latch. An input pin reads as pin_in after two clock edges of synchronization.
- R6: Writes to address 3 set and writes to address 4 clear interrupt-enable bits, one bit per pin, with zero bits left unchanged. The enables read back at read address 2.
- R7: A write to address 5 loads the edge-select register (1 = edge, 0 = level), read back at address 3. A write to address 6 loads the both-edge register (1 = both edges, 0 = rising only), read back at address 4. A write to address 7 changes nothing.
- R8: A level-sensitive pin is pending while its watched level is high. irq follows it and drops once the level falls.
- R9: An edge-sensitive pin in rising-only mode sets a sticky event latch on a rising edge but not on a falling edge. The latch holds until a write to address 2 has a one in that bit.
- R10: An edge-sensitive pin in both-edge mode also sets its event latch on a falling edge.
- R11: For an output pin, the watched level is the output latch, so a software set or clear write can raise an interrupt under the same level or edge rules.
- R12: When a write to address 2 with a one in a bit lands in the same cycle as a new edge event on that bit, the latch ends cleared.
- R13: irq is high exactly when some pin is both pending and enabled. Read address 5 returns the unmasked pending vector. Read addresses 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 direction, 1 set, 2 clear, 3 mask set, 4 mask clear, 5 edge select, 6 both-edge, 7 none) |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_addr | input | 3 | Read address (0 direction, 1 status, 2 mask, 3 edge select, 4 both-edge, 5 pending) |
| rd_data | output | NPINS | Combinational read data |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output latch levels to the pads |
| pin_oe | output | NPINS | Output enables to the pads |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume at most one register write per cycle, with wr_addr and wr_data valid whenever wr_en is high. Under that assumption the only set/clear collision is a clear write meeting an edge event, and that is the case the latch priority check covers. They also assume pin_in is synchronous enough that two flops give stable values. The bench changes pin_in and all bus inputs only just after the falling clock edge, and it holds pin levels for at least three cycles before it judges an interrupt. The clear-priority case is timed so that the clear write is captured on exactly the edge where the synchronized rising edge is detected.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    WA_DIR   = 3'd0,
    WA_SET   = 3'd1,
    WA_CLR   = 3'd2,
    WA_MSET  = 3'd3,
    WA_MCLR  = 3'd4,
    WA_SENSE = 3'd5,
    WA_BOTH  = 3'd6,
    WA_NONE  = 3'd7
  } wr_addr_e;

  typedef enum logic [REG_AW-1:0] {
    RA_DIR    = 3'd0,
    RA_STATUS = 3'd1,
    RA_MASK   = 3'd2,
    RA_SENSE  = 3'd3,
    RA_BOTH   = 3'd4,
    RA_PEND   = 3'd5
  } rd_addr_e;

  // One pin's edge event: rising always counts in edge mode, falling only with both-edge
  function automatic logic edge_hit_bit(input logic src, input logic prev,
                                        input logic edge_mode, input logic both);
    return edge_mode & ((src & ~prev) | (both & ~src & prev));
  endfunction

  // One pin's pending value: sticky latch in edge mode, live level otherwise
  function automatic logic pend_bit(input logic edge_mode, input logic latch,
                                    input logic src);
    return edge_mode ? latch : src;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= d[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_flag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      sense_q,
  output logic [W-1:0]      both_q,
  output logic [W-1:0]      clr_strobe
);

  // Data bits of a write aimed at one address, zero otherwise
  function automatic logic [W-1:0] hit(input logic en, input logic [REG_AW-1:0] a,
                                       input wr_addr_e target, input logic [W-1:0] d);
    return (en && (a == target)) ? d : '0;
  endfunction

  logic [W-1:0] set_m, clr_m, mset_m, mclr_m;
  logic         dir_wr, sense_wr, both_wr;

  assign set_m    = hit(wr_en, wr_addr, WA_SET,  wr_data);
  assign clr_m    = hit(wr_en, wr_addr, WA_CLR,  wr_data);
  assign mset_m   = hit(wr_en, wr_addr, WA_MSET, wr_data);
  assign mclr_m   = hit(wr_en, wr_addr, WA_MCLR, wr_data);
  assign dir_wr   = wr_en && (wr_addr == WA_DIR);
  assign sense_wr = wr_en && (wr_addr == WA_SENSE);
  assign both_wr  = wr_en && (wr_addr == WA_BOTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
    end else begin
      if (dir_wr)   dir_q   <= wr_data;
      if (sense_wr) sense_q <= wr_data;
      if (both_wr)  both_q  <= wr_data;
      out_q  <= (out_q  | set_m)  & ~clr_m;
      mask_q <= (mask_q | mset_m) & ~mclr_m;
    end
  end

  assign clr_strobe = clr_m;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_flag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] sense_q,
  input  logic [W-1:0] both_q,
  input  logic [W-1:0] mask_q,
  input  logic [W-1:0] clr_strobe,
  output logic [W-1:0] edge_evt,
  output logic [W-1:0] evt_latch,
  output logic [W-1:0] pending,
  output logic         irq
);

  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign edge_evt[i] = edge_hit_bit(src[i], prev_q[i], sense_q[i], both_q[i]);
    assign pending[i]  = pend_bit(sense_q[i], latch_q[i], src[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i]  <= 1'b0;
        latch_q[i] <= 1'b0;
      end else begin
        prev_q[i]  <= src[i];
        // a clear write wins over an event in the same cycle
        latch_q[i] <= (latch_q[i] | edge_evt[i]) & ~clr_strobe[i];
      end
    end
  end

  assign evt_latch = latch_q;
  assign irq       = |(pending & mask_q);

endmodule

// File: rtl/gpio_flag_ctrl.sv
module gpio_flag_ctrl
  import gpio_flag_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  logic [NPINS-1:0] dir_q, out_q, mask_q, sense_q, both_q, clr_strobe;
  logic [NPINS-1:0] in_sync, src;
  logic [NPINS-1:0] edge_evt, evt_latch, pending;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pin_in),
    .q (in_sync)
  );

  gpio_pin_regs #(.W(NPINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .dir_q      (dir_q),
    .out_q      (out_q),
    .mask_q     (mask_q),
    .sense_q    (sense_q),
    .both_q     (both_q),
    .clr_strobe (clr_strobe)
  );

  // Watched level: driven value for outputs, synchronized input otherwise
  assign src = (dir_q & out_q) | (~dir_q & in_sync);

  gpio_irq_unit #(.W(NPINS)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (src),
    .sense_q    (sense_q),
    .both_q     (both_q),
    .mask_q     (mask_q),
    .clr_strobe (clr_strobe),
    .edge_evt   (edge_evt),
    .evt_latch  (evt_latch),
    .pending    (pending),
    .irq        (irq)
  );

  always_comb begin
    case (rd_addr)
      RA_DIR:    rd_data = dir_q;
      RA_STATUS: rd_data = src;
      RA_MASK:   rd_data = mask_q;
      RA_SENSE:  rd_data = sense_q;
      RA_BOTH:   rd_data = both_q;
      RA_PEND:   rd_data = pending;
      default:   rd_data = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_flag_chk.sv
module gpio_flag_chk
  import gpio_flag_pkg::*;
#(
  parameter int NPINS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic [NPINS-1:0]  wr_data,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  edge_evt,
  input logic [NPINS-1:0]  evt_latch
);

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == WA_SET) |=> ((pin_out & $past(wr_data)) == $past(wr_data)));

  // R3
  set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == WA_SET) |=> (((pin_out ^ $past(pin_out)) & ~$past(wr_data)) == '0));

  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == WA_CLR) |=> ((pin_out & $past(wr_data)) == '0));

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == WA_DIR) |=> $stable(pin_oe));

  // R13
  no_mask_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R9
  latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_latch & ~$past(evt_latch) & ~$past(edge_evt)) == '0));

  // R12
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == WA_CLR) |=> ((evt_latch & $past(wr_data)) == '0));

endmodule

bind gpio_flag_ctrl gpio_flag_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .mask_q    (mask_q),
  .edge_evt  (edge_evt),
  .evt_latch (evt_latch)
);

// File: tb/tb_gpio_flag_ctrl.sv
module tb_gpio_flag_ctrl;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;
  logic         irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  gpio_flag_ctrl #(.NPINS(N)) dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
  );

  // {write addr, write data, read addr, expected read}
  localparam int NV = 10;
  localparam logic [37:0] VEC [NV] = '{
    {3'd0, 16'h00FF, 3'd0, 16'h00FF},  // R2 direction load
    {3'd1, 16'h0F0F, 3'd1, 16'h000F},  // R3 set, R5 status of outputs
    {3'd1, 16'h0030, 3'd1, 16'h003F},  // R3 zero bits untouched
    {3'd2, 16'h0005, 3'd1, 16'h003A},  // R4 clear
    {3'd3, 16'h8001, 3'd2, 16'h8001},  // R6 mask set
    {3'd3, 16'h0100, 3'd2, 16'h8101},  // R6 mask set keeps others
    {3'd4, 16'h8000, 3'd2, 16'h0101},  // R6 mask clear
    {3'd5, 16'h00F0, 3'd3, 16'h00F0},  // R7 edge select
    {3'd6, 16'h0C00, 3'd4, 16'h0C00},  // R7 both-edge
    {3'd7, 16'hFFFF, 3'd0, 16'h00FF}   // R7 address 7 ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [N-1:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; pin_in = '0;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    apply_reset();
    // R1 reset state
    rd_chk(3'd0, '0, "R1 dir");
    rd_chk(3'd2, '0, "R1 mask");
    rd_chk(3'd3, '0, "R1 sense");
    rd_chk(3'd4, '0, "R1 both");
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 irq", 32'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][37:35], VEC[i][34:19]);
      rd_chk(VEC[i][18:16], VEC[i][15:0], $sformatf("table row %0d (R2-R7)", i));
    end
    chk("R3 R4 pin_out", 32'(pin_out), 32'h0F3A);
    chk("R2 pin_oe", 32'(pin_oe), 32'h00FF);
    rd_chk(3'd6, '0, "R13 read 6 zero");

    // R5 synchronizer latency on an input pin
    apply_reset();
    pin_in = 16'h0100;
    wait_n(1);
    rd_chk(3'd1, 16'h0000, "R5 status after one edge");
    wait_n(1);
    rd_chk(3'd1, 16'h0100, "R5 status after two edges");

    // R8 level sensitivity, R13 masking
    wr(3'd3, 16'h0100);
    chk("R8 level irq high", 32'(irq), 1);
    rd_chk(3'd5, 16'h0100, "R13 pending");
    pin_in = 16'h0000;
    wait_n(3);
    chk("R8 level irq drops", 32'(irq), 0);
    wr(3'd4, 16'h0100);
    pin_in = 16'h0100;
    wait_n(3);
    chk("R13 masked pin no irq", 32'(irq), 0);
    rd_chk(3'd5, 16'h0100, "R13 masked still pending");

    // R9 rising-only sticky latch
    apply_reset();
    wr(3'd5, 16'h0002);
    wr(3'd3, 16'h0002);
    pin_in = 16'h0002;
    wait_n(3);
    chk("R9 rise latched", 32'(irq), 1);
    pin_in = 16'h0000;
    wait_n(3);
    chk("R9 latch sticky", 32'(irq), 1);
    wr(3'd2, 16'h0002);
    chk("R9 cleared by write", 32'(irq), 0);
    pin_in = 16'h0002;
    wait_n(3);
    wr(3'd2, 16'h0002);
    pin_in = 16'h0000;
    wait_n(3);
    chk("R9 fall ignored", 32'(irq), 0);

    // R10 both-edge mode
    wr(3'd6, 16'h0002);
    pin_in = 16'h0002;
    wait_n(3);
    chk("R10 rise latched", 32'(irq), 1);
    wr(3'd2, 16'h0002);
    pin_in = 16'h0000;
    wait_n(3);
    chk("R10 fall latched", 32'(irq), 1);

    // R11 output pin software interrupt, edge then level
    apply_reset();
    wr(3'd0, 16'h0010);
    wr(3'd5, 16'h0010);
    wr(3'd3, 16'h0010);
    wr(3'd1, 16'h0010);
    wait_n(2);
    chk("R11 edge on output set", 32'(irq), 1);
    wr(3'd2, 16'h0010);
    wait_n(2);
    chk("R11 output fall rising-only", 32'(irq), 0);
    wr(3'd5, 16'h0000);
    wr(3'd1, 16'h0010);
    wait_n(1);
    chk("R11 level on output high", 32'(irq), 1);

    // R12 clear write meets edge event in the same cycle
    apply_reset();
    wr(3'd5, 16'h0004);
    wr(3'd3, 16'h0004);
    pin_in = 16'h0004;
    wait_n(1);
    wr(3'd2, 16'h0004);
    wait_n(2);
    chk("R12 clear wins irq", 32'(irq), 0);
    rd_chk(3'd5, 16'h0000, "R12 clear wins pending");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule